// File: doc/BRIEF.md
# Error Latch with Safe Reset Release

This block drives an active-low error pin from a set of error event inputs. It runs on a slow free-running oscillator clock that is present from power-up. The error capture flops have no reset of their own, so at power-up they hold arbitrary values. Instead of resetting them, the block clocks a known idle value through them. It does this while its internal release is held back for a fixed number of slow-clock cycles after the asynchronous chip reset goes away. Only after that window can an error be latched onto the pin. A garbage bit left over from power-up can therefore never show up as a false fault.

During normal operation, any error input that is high at a sampling edge passes through a short capture pipeline and then sets a sticky latch. The latch drives the pin low. Software returns the pin high with a one-cycle clear strobe. A clear that meets a new error at the latch loses to the error.

Top module: `err_latch_safe_rel`

## Requirements
- R1: While `rst_n_async` is low, `err_n` is high, and it goes high as soon as reset is asserted, without waiting for a clock edge.
- R2: After `rst_n_async` rises, two edges pass through the release synchronizer and four more pass through the flush counter (`FLUSH_CYC`=4). The 7th rising edge after release is the first edge that samples the error inputs.
- R3: Throughout the stretch window `err_n` stays high, whatever `err_evt` and `sw_clr` do in that window.
- R4: An error input that is high at a sampling edge drives `err_n` low after `SYNC_STAGES` (2) further edges, so the pin falls after the third edge counted from the sampling edge.
- R5: Once `err_n` is low, it stays low for as long as no clear strobe arrives.
- R6: `sw_clr` high at an edge returns `err_n` high after that edge, provided no error is reaching the latch at that edge.
- R7: If an error sampled two edges earlier reaches the latch at the same edge as `sw_clr`, the error wins and `err_n` stays low.
- R8: All bits of `err_evt` are OR-combined, so an error on any single bit sets the latch.
- R9: Asserting reset again discards a latched error. After a new stretch window `err_n` is high until a fresh error arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Free-running slow oscillator clock |
| rst_n_async | input | 1 | Asynchronous chip reset, active low |
| err_evt | input | N_ERR | Error event inputs, active high |
| sw_clr | input | 1 | Software clear strobe, one cycle, active high |
| err_n | output | 1 | Error pin, low while an error is latched |

## Verification
The bench holds an error input high through the entire stretch window and then checks that the pin stays high after release. A design with a window that is too short would latch that stale error and pull the pin low. It lines up a clear strobe with an error that is just arriving at the latch; a design that gives the clear priority would wrongly release the pin. It also reasserts reset while an error is latched and checks that the pin rises at once and stays high through the following stretch. A design that kept the latched state across reset would come back low.

// File: rtl/err_latch_safe_rel.sv
module err_latch_safe_rel #(
  parameter int N_ERR       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FLUSH_CYC   = 4
) (
  input  logic             clk_slow,
  input  logic             rst_n_async,
  input  logic [N_ERR-1:0] err_evt,
  input  logic             sw_clr,
  output logic             err_n
);
  localparam int CW = $clog2(FLUSH_CYC + 1);

  logic [1:0]             rel_sync;
  logic                   rel_ok;
  logic [CW-1:0]          flush_cnt;
  logic                   ready;
  logic [SYNC_STAGES-1:0] evt_pipe;
  logic                   err_lat;

  always_ff @(posedge clk_slow or negedge rst_n_async)
    if (!rst_n_async) rel_sync <= '0;
    else              rel_sync <= {rel_sync[0], 1'b1};

  assign rel_ok = rel_sync[1];

  always_ff @(posedge clk_slow or negedge rst_n_async)
    if (!rst_n_async)          flush_cnt <= '0;
    else if (rel_ok && !ready) flush_cnt <= flush_cnt + 1'b1;

  assign ready = (flush_cnt == CW'(FLUSH_CYC));

  // capture flops carry no reset: they are flushed with zeros while not ready
  always_ff @(posedge clk_slow)
    if (!ready) begin
      evt_pipe <= '0;
      err_lat  <= 1'b0;
    end else begin
      evt_pipe <= SYNC_STAGES'({evt_pipe, |err_evt});
      err_lat  <= evt_pipe[SYNC_STAGES-1] | (err_lat & ~sw_clr);
    end

  assign err_n = ~(err_lat & ready);
endmodule

// File: rtl/err_latch_safe_rel_chk.sv
module err_latch_safe_rel_chk (
  input logic clk,
  input logic rst_n,
  input logic err_n,
  input logic sw_clr,
  input logic ready,
  input logic rel_ok,
  input logic latch_in
);
  // R1
  a_r1_pin_high_in_reset: assert property (@(posedge clk)
    !rst_n |-> err_n);

  // R3
  a_r3_pin_high_while_flushing: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> err_n);

  // R2
  a_r2_release_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(rel_ok));

  // R2
  a_r2_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R5
  a_r5_error_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !err_n && !sw_clr) |=> !err_n);

  // R6
  a_r6_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sw_clr && !latch_in) |=> err_n);

  // R7
  a_r7_error_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && latch_in) |=> !err_n);
endmodule

bind err_latch_safe_rel err_latch_safe_rel_chk u_chk (
  .clk     (clk_slow),
  .rst_n   (rst_n_async),
  .err_n   (err_n),
  .sw_clr  (sw_clr),
  .ready   (ready),
  .rel_ok  (rel_ok),
  .latch_in(evt_pipe[SYNC_STAGES-1])
);

// File: tb/err_latch_safe_rel_tb.sv
`timescale 1ns/1ps
module err_latch_safe_rel_tb_top;
  localparam int N_ERR = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_ERR-1:0] err_evt = '0;
  logic             sw_clr = 1'b0;
  logic             err_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string req; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  err_latch_safe_rel #(.N_ERR(N_ERR), .SYNC_STAGES(2), .FLUSH_CYC(4)) dut_i (
    .clk_slow(clk), .rst_n_async(rst_n), .err_evt(err_evt),
    .sw_clr(sw_clr), .err_n(err_n)
  );

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: err_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: called at a negedge, applies inputs, queues the pin value expected after the next posedge
  task automatic cyc(logic [N_ERR-1:0] e, bit c, bit exp, string req);
    item_t it;
    err_evt = e;
    sw_clr  = c;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: pops one expectation per posedge
  always begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(err_n, it.exp, it.req);
    end
  end

  initial begin
    @(negedge clk);
    cyc(4'b1111, 1'b0, 1'b1, "R1");
    cyc(4'b1111, 1'b1, 1'b1, "R1");
    cyc(4'b0000, 1'b0, 1'b1, "R1");
    rst_n = 1'b1;
    // stretch window: error held high, clear pulsed, pin must stay high
    for (int i = 0; i < 6; i++) cyc(4'b0101, (i == 2), 1'b1, "R3");
    cyc(4'b0000, 1'b0, 1'b1, "R2");
    cyc(4'b0000, 1'b0, 1'b1, "R2");
    cyc(4'b0000, 1'b0, 1'b1, "R2");
    // single high bit, latency and hold
    cyc(4'b1000, 1'b0, 1'b1, "R8");
    cyc(4'b0000, 1'b0, 1'b1, "R4");
    cyc(4'b0000, 1'b0, 1'b0, "R4");
    cyc(4'b0000, 1'b0, 1'b0, "R5");
    cyc(4'b0000, 1'b0, 1'b0, "R5");
    cyc(4'b0000, 1'b1, 1'b1, "R6");
    cyc(4'b0000, 1'b0, 1'b1, "R6");
    // clear collides with an error arriving at the latch
    cyc(4'b0001, 1'b0, 1'b1, "R7");
    cyc(4'b0000, 1'b0, 1'b1, "R7");
    cyc(4'b0000, 1'b1, 1'b0, "R7");
    cyc(4'b0000, 1'b0, 1'b0, "R7");
    cyc(4'b0000, 1'b1, 1'b1, "R6");
    // another single bit
    cyc(4'b0010, 1'b0, 1'b1, "R8");
    cyc(4'b0000, 1'b0, 1'b1, "R8");
    cyc(4'b0000, 1'b0, 1'b0, "R8");
    cyc(4'b0000, 1'b0, 1'b0, "R5");
    @(posedge clk);
    #2;
    // asynchronous reset with an error latched
    rst_n = 1'b0;
    #1;
    check(err_n, 1'b1, "R1");
    @(negedge clk);
    cyc(4'b0000, 1'b0, 1'b1, "R9");
    cyc(4'b0000, 1'b0, 1'b1, "R9");
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cyc(4'b0000, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 4; i++) cyc(4'b0000, 1'b0, 1'b1, "R9");
    // pin still works after the second release
    cyc(4'b0100, 1'b0, 1'b1, "R4");
    cyc(4'b0000, 1'b0, 1'b1, "R4");
    cyc(4'b0000, 1'b0, 1'b0, "R4");
    @(posedge clk);
    #2;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #1000000;
    join_any
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule